// File: doc/BRIEF.md
# Periodic Wake and Watchdog Controller

This controller sits beside a host processor that spends most of its time asleep. Counting ticks of a slow enable, it raises a short wake pulse at the start of each programmed interval. The host must answer each wake with a rising edge on its acknowledge input. The answer must come early enough, leaving at least a two-tick guard before the next interval begins. If the answer is missing or late, the controller drives its active-low reset output for a fixed pulse in place of the next wake, and counting then starts over.

An acknowledge arriving while the wake pulse is still high ends that pulse early. An acknowledge only clears the pending-answer state; the interval counter keeps running, so the wake cadence is unaffected. While the startup-busy flag or the external-reset request is high, reset is held low and every counter is held at zero. Once both fall, the controller emits one reset pulse and then runs a first interval that has no wake at its start.

Top module: `wakeWdTop`

## Requirements
- R1: While the asynchronous reset `rstN` is low, or `startBusy` is high, `rstNOut` is 0 and `wakeOut` is 0.
- R2: After `startBusy` and `extReset` are both low, `rstNOut` stays 0 for exactly RST_TICKS (default 32) ticks and rises on the clock edge of the last of them.
- R3: The first interval after any reset pulse starts without a wake; `wakeOut` first rises on the tick that completes `intervalTicks` ticks after `rstNOut` rose.
- R4: An uninterrupted wake pulse stays high for exactly WAKE_TICKS (default 2) ticks.
- R5: When every wake is acknowledged in time, wake rising edges are exactly `intervalTicks` ticks apart, and an acknowledge does not move the next wake.
- R6: An acknowledge is a 0-to-1 transition of `doneIn` seen through a two-stage synchronizer. If it comes while `wakeOut` is high, `wakeOut` falls on the third clock edge after `doneIn` rises and is still high after the second.
- R7: An acknowledge counts only when fewer than `intervalTicks - GUARD_TICKS` ticks (default guard 2) have elapsed since the wake. A later edge is ignored and the interval ends as if none had come.
- R8: If an interval that began with a wake ends unacknowledged, no wake is issued. `rstNOut` goes low for RST_TICKS ticks instead, and a wake-free first interval follows.
- R9: `extReset` high forces `wakeOut` and `rstNOut` to 0 from the next clock edge and zeroes all counters. After release, the behaviour of R2 and R3 follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-clock enable marking each timing tick |
| intervalTicks | input | IW (20) | Interval length in ticks, at least 10, held steady while running |
| doneIn | input | 1 | Acknowledge from the host, asynchronous |
| startBusy | input | 1 | High while startup measurement is in progress |
| extReset | input | 1 | External reset request |
| wakeOut | output | 1 | Wake pulse, active high |
| rstNOut | output | 1 | Reset to host, active low |

## Verification
Outputs are registered, so a result caused by a tick appears on the clock edge that samples `tickEn`. The bench steps one tick at a time and reads the outputs at the following falling edge. An acknowledge passes through two synchronizer flops before the control register sees it. The bench therefore expects a cut wake to still be high after the second edge following the `doneIn` rise and low after the third, and it samples at the falling edges in between. Interval ends, guard-window edges and reset-pulse lengths are counted in whole ticks from the previous observed transition. Every check is placed at the exact tick count that the requirement predicts.

// File: rtl/wakeWdPkg.sv
package wakeWdPkg;

  // strobes from control to datapath
  typedef struct packed {
    logic clrInt;    // zero the interval counter
    logic runInt;    // interval counter advances on ticks
    logic clrPulse;  // zero the pulse-width counter
    logic incPulse;  // pulse-width counter advances on ticks
  } ctrlStrb_t;

  // status from datapath to control
  typedef struct packed {
    logic intEnd;        // tick that closes the current interval
    logic ackWindow;     // still ahead of the guard ticks
    logic wakeWidthDone; // tick that closes the wake pulse
    logic rstWidthDone;  // tick that closes the reset pulse
    logic doneRise;      // synchronized rising edge of the acknowledge
  } dpStat_t;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_RSTP  = 2'd1,
    ST_RUN   = 2'd2
  } wdState_t;

endpackage

// File: rtl/wakeWdDatapath.sv
module wakeWdDatapath
  import wakeWdPkg::*;
#(
  parameter int IW          = 20,
  parameter int WAKE_TICKS  = 2,
  parameter int GUARD_TICKS = 2,
  parameter int RST_TICKS   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic [IW-1:0] intervalTicks,
  input  logic          doneIn,
  input  ctrlStrb_t     strb,
  output dpStat_t       stat,
  output logic [IW-1:0] intCnt
);

  localparam int PW = $clog2(RST_TICKS + 1);
  localparam logic [PW-1:0] WAKE_LAST = PW'(WAKE_TICKS - 1);
  localparam logic [PW-1:0] RST_LAST  = PW'(RST_TICKS - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncPrev;
  logic                   syncOut;
  logic [PW-1:0]          pulseCnt;
  logic [IW-1:0]          lastIdx;
  logic [IW-1:0]          guardIdx;

  assign syncOut  = syncQ[SYNC_STAGES-1];
  assign lastIdx  = intervalTicks - IW'(1);
  assign guardIdx = intervalTicks - IW'(GUARD_TICKS);

  // acknowledge synchronizer and edge detector, sampled every clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '0;
      syncPrev <= 1'b0;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-2:0], doneIn};
      syncPrev <= syncOut;
    end
  end

  // interval counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intCnt <= '0;
    end else if (strb.clrInt) begin
      intCnt <= '0;
    end else if (strb.runInt && tickEn) begin
      intCnt <= (intCnt >= lastIdx) ? '0 : intCnt + IW'(1);
    end
  end

  // pulse-width counter shared by wake and reset pulses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (strb.clrPulse) begin
      pulseCnt <= '0;
    end else if (strb.incPulse && tickEn && pulseCnt != RST_LAST) begin
      pulseCnt <= pulseCnt + PW'(1);
    end
  end

  always_comb begin
    stat.intEnd        = tickEn && strb.runInt && (intCnt >= lastIdx);
    stat.ackWindow     = intCnt < guardIdx;
    stat.wakeWidthDone = tickEn && (pulseCnt == WAKE_LAST);
    stat.rstWidthDone  = tickEn && (pulseCnt == RST_LAST);
    stat.doneRise      = syncOut && !syncPrev;
  end

  // R2
  // pulse counter never runs past the reset width
  pulse_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= RST_LAST);

endmodule

// File: rtl/wakeWdControl.sv
module wakeWdControl
  import wakeWdPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickEn,
  input  logic      startBusy,
  input  logic      extReset,
  input  dpStat_t   stat,
  output ctrlStrb_t strb,
  output logic      wakeOut,
  output logic      rstNOut
);

  wdState_t state, stateNxt;
  logic     wakeR, wakeNxt;
  logic     ackPend, ackPendNxt;
  logic     holdReq;

  assign holdReq = startBusy || extReset;

  always_comb begin
    stateNxt   = state;
    wakeNxt    = wakeR;
    ackPendNxt = ackPend;
    strb       = '0;
    if (holdReq) begin
      stateNxt      = ST_HOLD;
      wakeNxt       = 1'b0;
      ackPendNxt    = 1'b0;
      strb.clrInt   = 1'b1;
      strb.clrPulse = 1'b1;
    end else begin
      unique case (state)
        ST_HOLD: begin
          strb.clrInt   = 1'b1;
          strb.clrPulse = 1'b1;
          stateNxt      = ST_RSTP;
        end
        ST_RSTP: begin
          strb.clrInt   = 1'b1;
          strb.incPulse = 1'b1;
          if (stat.rstWidthDone) begin
            stateNxt      = ST_RUN;
            strb.clrPulse = 1'b1;
            ackPendNxt    = 1'b0;
          end
        end
        ST_RUN: begin
          strb.runInt   = 1'b1;
          strb.incPulse = wakeR;
          if (wakeR && (stat.wakeWidthDone || stat.doneRise)) begin
            wakeNxt = 1'b0;
          end
          if (ackPend && stat.doneRise && stat.ackWindow) begin
            ackPendNxt = 1'b0;
          end
          if (stat.intEnd) begin
            strb.clrPulse = 1'b1;
            if (ackPend) begin
              stateNxt    = ST_RSTP;
              strb.clrInt = 1'b1;
              wakeNxt     = 1'b0;
              ackPendNxt  = 1'b0;
            end else begin
              wakeNxt    = 1'b1;
              ackPendNxt = 1'b1;
            end
          end
        end
        default: stateNxt = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_HOLD;
      wakeR   <= 1'b0;
      ackPend <= 1'b0;
    end else begin
      state   <= stateNxt;
      wakeR   <= wakeNxt;
      ackPend <= ackPendNxt;
    end
  end

  assign wakeOut = wakeR;
  assign rstNOut = (state == ST_RUN);

  // R9
  ext_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    extReset |=> (!wakeOut && !rstNOut));

  // R8
  wake_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut |-> rstNOut);

  // R6
  wake_cut_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wakeOut && stat.doneRise) |=> !wakeOut);

  // R2
  rst_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstNOut) |-> $past(tickEn));

endmodule

// File: rtl/wakeWdTop.sv
module wakeWdTop
  import wakeWdPkg::*;
#(
  parameter int IW          = 20,
  parameter int WAKE_TICKS  = 2,
  parameter int GUARD_TICKS = 2,
  parameter int RST_TICKS   = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic [IW-1:0] intervalTicks,
  input  logic          doneIn,
  input  logic          startBusy,
  input  logic          extReset,
  output logic          wakeOut,
  output logic          rstNOut
);

  ctrlStrb_t     strb;
  dpStat_t       stat;
  logic [IW-1:0] intCnt;

  wakeWdDatapath #(
    .IW(IW), .WAKE_TICKS(WAKE_TICKS), .GUARD_TICKS(GUARD_TICKS),
    .RST_TICKS(RST_TICKS), .SYNC_STAGES(2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .intervalTicks(intervalTicks),
    .doneIn(doneIn), .strb(strb), .stat(stat), .intCnt(intCnt)
  );

  wakeWdControl u_ctl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .startBusy(startBusy),
    .extReset(extReset), .stat(stat), .strb(strb),
    .wakeOut(wakeOut), .rstNOut(rstNOut)
  );

  // R5
  // every wake starts with the interval counter at zero
  wake_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeOut) |-> (intCnt == '0));

endmodule

// File: tb/wakeWdTop_tb.sv
module wakeWdTop_tb;

  localparam int IW  = 20;
  localparam int N   = 10;
  localparam int RT  = 32;
  localparam int NV  = 5;
  // per vector: tick count after the wake at which DONE pulses (15 = never)
  localparam int ACK_AT   [NV] = '{3, 7, 0, 8, 15};
  // expected result at the end of that interval: 1 = wake, 0 = reset
  localparam bit EXP_WAKE [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0};

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tickEn = 1'b0;
  logic [IW-1:0] intervalTicks = IW'(N);
  logic          doneIn = 1'b0;
  logic          startBusy = 1'b1;
  logic          extReset = 1'b0;
  logic          wakeOut, rstNOut;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  always #4 clk = ~clk;

  wakeWdTop #(.IW(IW)) u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .intervalTicks(intervalTicks),
    .doneIn(doneIn), .startBusy(startBusy), .extReset(extReset),
    .wakeOut(wakeOut), .rstNOut(rstNOut)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // one tick; called and returns at a falling edge
  task automatic tickStep();
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic donePulse();
    doneIn = 1'b1;
    repeat (4) @(negedge clk);
    doneIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // from reset-pulse start: reset width, then wake-free first interval
  task automatic recover(input string tag);
    for (int i = 0; i < RT - 1; i++) tickStep();
    chk({tag, " R2/R8 rst still low"}, rstNOut, 1'b0);
    tickStep();
    chk({tag, " R2/R8 rst released"}, rstNOut, 1'b1);
    for (int i = 0; i < N - 1; i++) tickStep();
    chk({tag, " R3 no wake in first interval"}, wakeOut, 1'b0);
    tickStep();
    chk({tag, " R3 first wake"}, wakeOut, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset rstNOut", rstNOut, 1'b0);
    chk("R1 reset wakeOut", wakeOut, 1'b0);
    rstN = 1'b1;
    for (int i = 0; i < 40; i++) tickStep();
    chk("R1 busy rstNOut", rstNOut, 1'b0);
    chk("R1 busy wakeOut", wakeOut, 1'b0);
    startBusy = 1'b0;
    @(negedge clk);
    recover("startup");

    // vector walk: each starts just after a wake rose
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < N; k++) begin
        if (k == ACK_AT[v]) begin
          if (wakeOut) begin
            doneIn = 1'b1;
            repeat (2) @(negedge clk);
            chk("R6 wake held two edges", wakeOut, 1'b1);
            @(negedge clk);
            chk("R6 wake cut by ack", wakeOut, 1'b0);
            repeat (2) @(negedge clk);
            doneIn = 1'b0;
            repeat (4) @(negedge clk);
          end else begin
            donePulse();
          end
        end
        tickStep();
        if (ACK_AT[v] != 0 && k == 0) chk("R4 wake after 1 tick", wakeOut, 1'b1);
        if (ACK_AT[v] != 0 && k == 1) chk("R4 wake after 2 ticks", wakeOut, 1'b0);
        if (k == N - 2) chk("R5 no early wake", wakeOut, 1'b0);
      end
      if (EXP_WAKE[v]) begin
        chk("R5/R7 wake on schedule", wakeOut, 1'b1);
        chk("R5/R7 rst high", rstNOut, 1'b1);
      end else begin
        chk("R7/R8 reset replaces wake", rstNOut, 1'b0);
        chk("R8 wake suppressed", wakeOut, 1'b0);
        recover("miss");
      end
    end

    // R9: external reset mid-wake
    extReset = 1'b1;
    @(negedge clk);
    chk("R9 wake forced low", wakeOut, 1'b0);
    chk("R9 rst forced low", rstNOut, 1'b0);
    for (int i = 0; i < 5; i++) tickStep();
    chk("R9 rst held low", rstNOut, 1'b0);
    extReset = 1'b0;
    @(negedge clk);
    recover("R9 ext");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #(400000);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule